// File: doc/BRIEF.md
# Single-Bit Right Shift and Sign-Extend Unit

This is a purely combinational 32-bit unary datapath unit for a processor execute stage. It takes one source operand, the current value of the carry flag and a 3-bit operation select. It returns a result word, a proposed new carry value and a write-enable for the carry flag. The carry register itself sits outside the unit. The unit covers two families of operations.

The first family is three one-bit right shifts. In each of them the bit shifted out of position 0 becomes the new carry. The three shifts differ only in what enters bit 31: the old sign bit, the old carry flag, or zero. The second family is sign extension from a byte or from a halfword. Those two operations leave the carry flag alone. Select codes outside the five defined operations give a zero result and do not write the carry.

Top module: `shsx_unit`

## Requirements
- R1: For the three shift codes (0, 1, 2), `carry_o` equals `src_i[0]` and `carry_we_o` is 1.
- R2: Code 0 (arithmetic shift) gives `result_o[30:0] = src_i[31:1]`, and `result_o[31]` equals `src_i[31]`.
- R3: Code 1 (shift through carry) gives `result_o[30:0] = src_i[31:1]`, and `result_o[31]` equals `carry_i`.
- R4: Code 2 (logical shift) gives `result_o[30:0] = src_i[31:1]`, and `result_o[31]` is 0.
- R5: Code 3 (byte extend) gives `result_o[7:0] = src_i[7:0]`, and every bit of `result_o[31:8]` equals `src_i[7]`.
- R6: Code 4 (halfword extend) gives `result_o[15:0] = src_i[15:0]`, and every bit of `result_o[31:16]` equals `src_i[15]`.
- R7: `carry_we_o` is 1 only for codes 0 to 2. For codes 3 and 4 it is 0, and `carry_o` then equals `carry_i`.
- R8: Codes 5, 6 and 7 give `result_o = 0` and `carry_we_o = 0`, and `carry_o` equals `carry_i`.
- R9: For every code except 1, `result_o` does not depend on `carry_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation select (0 arith shift, 1 shift through carry, 2 logical shift, 3 byte extend, 4 halfword extend) |
| src_i | input | 32 | Source operand |
| carry_i | input | 1 | Current carry flag value |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | New carry value; equals `carry_i` when no write is requested |
| carry_we_o | output | 1 | Carry flag write-enable |

## Verification
The shift-through-carry operation does two things in the same evaluation. It consumes the old carry, which goes into bit 31. It also produces the new carry, which comes from bit 0. The bench provokes this by driving every operand with both carry values, including operands whose bit 0 is the opposite of `carry_i`. In those cases a design that mixed up the old and new carry would give the wrong bit 31 or the wrong `carry_o`. Each result is compared with an arithmetic model in the bench, built from shifts and replication. The same sweep runs over all eight select codes, so the bench also shows that the carry input leaves the other operations unchanged.

// File: rtl/shsx_pkg.sv
package shsx_pkg;
  localparam int DATA_W = 32;
  localparam int OP_W   = 3;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  typedef enum logic [OP_W-1:0] {
    OP_SHR_ARITH = 3'd0,
    OP_SHR_CARRY = 3'd1,
    OP_SHR_LOGIC = 3'd2,
    OP_SEXT_BYTE = 3'd3,
    OP_SEXT_HALF = 3'd4
  } shsx_op_e;
endpackage

// File: rtl/shsx_rshift1.sv
module shsx_rshift1 #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  input  logic         fill_bit,
  output logic [W-1:0] res,
  output logic         out_bit
);
  always_comb begin
    res     = {fill_bit, src[W-1:1]};
    out_bit = src[0];
  end

  // R2/R3/R4: lower bits always carry the shifted source
  always_comb begin
    a_r2_low_bits: assert (res[W-2:0] == src[W-1:1])
      else $error("low bits not shifted source");
  end
endmodule

// File: rtl/shsx_sext.sv
module shsx_sext #(
  parameter int FROM_W = 8,
  parameter int W      = 32
) (
  input  logic [FROM_W-1:0] src,
  output logic [W-1:0]      res
);
  localparam int EXT_W = W - FROM_W;

  always_comb begin
    res = {{EXT_W{src[FROM_W-1]}}, src};
  end

  // R5/R6: upper field is uniform and matches the source sign bit
  always_comb begin
    a_r5_upper_uniform: assert (res[W-1:FROM_W] == {EXT_W{res[FROM_W-1]}})
      else $error("extension field not uniform");
  end
endmodule

// File: rtl/shsx_unit.sv
module shsx_unit
  import shsx_pkg::*;
(
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] src_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              carry_we_o
);
  localparam int N_SEXT = 2;

  logic              fill_bit;
  logic [DATA_W-1:0] shr_res;
  logic              shr_out;
  logic [DATA_W-1:0] sext_res [N_SEXT];
  shsx_op_e          op;

  assign op = shsx_op_e'(op_sel);

  always_comb begin
    unique case (op)
      OP_SHR_ARITH: fill_bit = src_i[DATA_W-1];
      OP_SHR_CARRY: fill_bit = carry_i;
      default:      fill_bit = 1'b0;
    endcase
  end

  shsx_rshift1 #(.W(DATA_W)) u_shr (
    .src      (src_i),
    .fill_bit (fill_bit),
    .res      (shr_res),
    .out_bit  (shr_out)
  );

  for (genvar g = 0; g < N_SEXT; g++) begin : g_sext
    localparam int FW = (g == 0) ? BYTE_W : HALF_W;
    shsx_sext #(.FROM_W(FW), .W(DATA_W)) u_sext (
      .src (src_i[FW-1:0]),
      .res (sext_res[g])
    );
  end

  always_comb begin
    result_o   = '0;
    carry_o    = carry_i;
    carry_we_o = 1'b0;
    case (op)
      OP_SHR_ARITH, OP_SHR_CARRY, OP_SHR_LOGIC: begin
        result_o   = shr_res;
        carry_o    = shr_out;
        carry_we_o = 1'b1;
      end
      OP_SEXT_BYTE: result_o = sext_res[0];
      OP_SEXT_HALF: result_o = sext_res[1];
      default: ;
    endcase
  end

  // Port-level checks
  always_comb begin
    if (op_sel <= 3'd2) begin
      a_r1_carry_from_lsb: assert (carry_we_o && (carry_o == src_i[0]))
        else $error("R1 shift carry wrong");
    end
    if (op_sel == 3'd0) begin
      a_r2_sign_fill: assert (result_o[DATA_W-1] == src_i[DATA_W-1])
        else $error("R2 msb wrong");
    end
    if (op_sel == 3'd1) begin
      a_r3_carry_fill: assert (result_o[DATA_W-1] == carry_i)
        else $error("R3 msb wrong");
    end
    if (op_sel == 3'd2) begin
      a_r4_zero_fill: assert (!result_o[DATA_W-1])
        else $error("R4 msb wrong");
    end
    if (op_sel == 3'd3 || op_sel == 3'd4) begin
      a_r7_sext_no_carry: assert (!carry_we_o && (carry_o == carry_i))
        else $error("R7 sext touched carry");
    end
    if (op_sel >= 3'd5) begin
      a_r8_unused_zero: assert ((result_o == '0) && !carry_we_o && (carry_o == carry_i))
        else $error("R8 unused code active");
    end
  end
endmodule

// File: tb/tb_shsx_unit.sv
`timescale 1ns/1ps
module tb_shsx_unit;
  logic clk;
  logic rst_n;
  logic [2:0]  op_sel;
  logic [31:0] src_i;
  logic        carry_i;
  logic [31:0] result_o;
  logic        carry_o;
  logic        carry_we_o;

  int n_checks;
  int n_fail;
  bit done;

  shsx_unit dut (
    .op_sel     (op_sel),
    .src_i      (src_i),
    .carry_i    (carry_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .carry_we_o (carry_we_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d src=%h cin=%0b actual=%h expected=%h",
               req, op_sel, src_i, carry_i, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [31:0] s, input logic c);
    logic [31:0] e_res;
    logic        e_we;
    logic        e_c;
    string       rq;
    @(negedge clk);
    op_sel  = op;
    src_i   = s;
    carry_i = c;
    #1;
    e_we = 1'b0;
    e_c  = c;
    case (op)
      3'd0: begin e_res = 32'($signed(s) >>> 1); e_we = 1'b1; e_c = s[0]; rq = "R2/R9"; end
      3'd1: begin e_res = {c, s[31:1]};          e_we = 1'b1; e_c = s[0]; rq = "R3"; end
      3'd2: begin e_res = s >> 1;                e_we = 1'b1; e_c = s[0]; rq = "R4/R9"; end
      3'd3: begin e_res = {{24{s[7]}}, s[7:0]};   rq = "R5/R9"; end
      3'd4: begin e_res = {{16{s[15]}}, s[15:0]}; rq = "R6/R9"; end
      default: begin e_res = 32'h0; rq = "R8/R9"; end
    endcase
    cmp(rq, result_o, e_res);
    cmp((op <= 3'd2) ? "R1" : ((op <= 3'd4) ? "R7" : "R8"), {31'h0, carry_o}, {31'h0, e_c});
    cmp((op <= 3'd4) ? "R7" : "R8", {31'h0, carry_we_o}, {31'h0, e_we});
  endtask

  localparam int NPAT = 12;
  logic [31:0] pats [NPAT];

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    op_sel   = 3'd7;
    src_i    = 32'h0;
    carry_i  = 1'b0;
    pats[0]  = 32'h0000_0000; pats[1]  = 32'hFFFF_FFFF;
    pats[2]  = 32'h8000_0000; pats[3]  = 32'h0000_0001;
    pats[4]  = 32'h0000_0080; pats[5]  = 32'h0000_8000;
    pats[6]  = 32'h0000_007F; pats[7]  = 32'h0000_7FFF;
    pats[8]  = 32'hAAAA_AAAA; pats[9]  = 32'h5555_5555;
    pats[10] = 32'h8000_0001; pats[11] = 32'h7FFF_FF7E;
    repeat (3) @(negedge clk);
    // Reset/idle state: unused code 7 gives zero, no carry write (R8)
    #1;
    cmp("R8", result_o, 32'h0);
    cmp("R8", {31'h0, carry_we_o}, 32'h0);
    rst_n = 1'b1;
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < NPAT; p++)
          apply(3'(op), pats[p], 1'(c));
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom;
      for (int op = 0; op < 8; op++) begin
        apply(3'(op), r, 1'b0);
        apply(3'(op), r, 1'b1);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule